// File: doc/BRIEF.md
# Truncated Binary Exponential Backoff Generator

This block sits beside a half-duplex transmit engine. Each time the engine sees a collision it pulses a request together with its 4-bit count of consecutive collisions. One cycle later the block returns either a random number of slot times to wait before the next attempt, or a discard pulse that tells the engine to drop the frame. One slot time is 512 bit times. Counting out the slots is left to the engine.

The random number comes from a free-running 16-bit maximal-length LFSR that advances on every clock cycle. For the nth consecutive collision, the low k = min(n, 10) bits of the LFSR are kept and the rest are cleared, so the wait r lies in 0 <= r < 2^k. The range doubles with each collision until it reaches 1024. A 4-bit count cannot represent the sixteenth collision. To cover it, the block keeps a one-bit extension: it is armed by a request carrying count 15. An armed block treats a following request with count 0 as collision sixteen and discards the frame instead of returning a wait.

While the partition input is high, requests are ignored completely.

Top module: `backoff_gen`

## Requirements
- R1: While `rst` is high on a clock edge, `slots` becomes 0, `slots_vld` becomes 0 and `discard` becomes 0, and the LFSR is loaded with the seed 16'hACE1.
- R2: The LFSR shifts left once per clock cycle outside reset. The new bit 0 is the XOR of the old bits 15, 13, 12 and 10.
- R3: A request with partition low and `coll_cnt` = n, where n is 1 to 10, gives `slots_vld` = 1 on the next cycle. In that cycle `slots` equals the low n bits of the LFSR value present at the request edge, and its upper bits are zero.
- R4: A request with `coll_cnt` from 11 to 15 works in the same way with k = 10, so `slots` holds the low 10 LFSR bits.
- R5: A request with `coll_cnt` = 0 while the block is not armed gives `slots_vld` with `slots` = 0.
- R6: A request with `coll_cnt` = 15 arms the block. A request with `coll_cnt` = 0 while armed gives `discard` = 1 for one cycle, no `slots_vld`, and `slots` = 0, and it disarms the block.
- R7: Once armed, any accepted request with `coll_cnt` from 1 to 14 disarms the block and returns a normal wait. A further request with count 15 keeps it armed.
- R8: A request made while `partition` is high produces no `slots_vld` and no `discard`, and it leaves the armed state unchanged.
- R9: `slots_vld` and `discard` are single-cycle pulses that never occur together, and neither occurs without an accepted request in the previous cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Backoff request strobe, one per collision |
| coll_cnt | input | 4 | Consecutive collision count from the transmit engine |
| partition | input | 1 | Line partitioned; requests are ignored |
| slots | output | 10 | Random wait in slot times |
| slots_vld | output | 1 | `slots` is valid this cycle |
| discard | output | 1 | Sixteenth consecutive collision: drop the frame |

## Verification
The assertions assume that `coll_cnt` and `partition` are stable and defined in any cycle where `req` is high. They also assume that the engine steps the count one collision at a time, so that the wrap from 15 to 0 means collision sixteen. The bench changes all inputs only at the falling edge. Its random stimulus favours counts 0 and 15 so that the arm-and-wrap path is exercised often. It also drives partition-blocked requests in the middle of an armed sequence, to show that the armed state survives them.

// File: rtl/backoff_pkg.sv
package backoff_pkg;

    localparam int LFSR_W    = 16;
    localparam int OUT_W     = 10;
    localparam int CNT_W     = 4;
    localparam int K_MAX     = 10;
    localparam logic [LFSR_W-1:0] LFSR_SEED = 16'hACE1;
    // x^16 + x^14 + x^13 + x^11 + 1 as a left-shift tap mask over bits 15,13,12,10
    localparam logic [LFSR_W-1:0] LFSR_TAPS = 16'hB400;
    localparam int K_W       = $clog2(K_MAX + 1);

    typedef enum logic [1:0] {
        ACT_NONE    = 2'd0,
        ACT_SLOTS   = 2'd1,
        ACT_DISCARD = 2'd2
    } bo_action_t;

    typedef struct packed {
        logic             vld;
        logic             drop;
        logic [OUT_W-1:0] slots;
    } bo_result_t;

    function automatic logic [K_W-1:0] exp_cap(input logic [CNT_W-1:0] n);
        if (int'(n) > K_MAX) return K_W'(K_MAX);
        return K_W'(n);
    endfunction

endpackage

// File: rtl/backoff_lfsr.sv
module backoff_lfsr
    import backoff_pkg::*;
#(
    parameter int                WIDTH = LFSR_W,
    parameter logic [WIDTH-1:0]  SEED  = LFSR_SEED,
    parameter logic [WIDTH-1:0]  TAPS  = LFSR_TAPS
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WIDTH-1:0] state
);
    logic fb;

    assign fb = ^(state & TAPS);

    always_ff @(posedge clk) begin
        if (rst) state <= SEED;
        else     state <= {state[WIDTH-2:0], fb};
    end
endmodule

// File: rtl/backoff_mask.sv
module backoff_mask
    import backoff_pkg::*;
#(
    parameter int W  = OUT_W,
    parameter int CW = CNT_W
) (
    input  logic [W-1:0]  raw,
    input  logic [CW-1:0] coll,
    output logic [W-1:0]  slots
);
    logic [K_W-1:0] k;
    logic [W:0]     top_bit;
    logic [W-1:0]   keep;

    always_comb begin
        k       = exp_cap(coll);
        top_bit = (W+1)'(1) << k;
        keep    = top_bit[W-1:0] - W'(1);
        slots   = raw & keep;
    end
endmodule

// File: rtl/backoff_wrap_tracker.sv
module backoff_wrap_tracker
    import backoff_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic          partition,
    input  logic [CW-1:0] coll,
    output bo_action_t    action
);
    localparam logic [CW-1:0] CNT_TOP = {CW{1'b1}};

    logic armed;
    logic take;
    logic wrap_hit;

    always_comb begin
        take     = req && !partition;
        wrap_hit = take && armed && (coll == '0);
        if (!take)        action = ACT_NONE;
        else if (wrap_hit) action = ACT_DISCARD;
        else               action = ACT_SLOTS;
    end

    always_ff @(posedge clk) begin
        if (rst)       armed <= 1'b0;
        else if (take) armed <= (coll == CNT_TOP);
    end
endmodule

// File: rtl/backoff_gen.sv
module backoff_gen
    import backoff_pkg::*;
#(
    parameter int W  = OUT_W,
    parameter int CW = CNT_W,
    parameter int LW = LFSR_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [CW-1:0] coll_cnt,
    input  logic          partition,
    output logic [W-1:0]  slots,
    output logic          slots_vld,
    output logic          discard
);
    logic [LW-1:0] lfsr_q;
    logic [W-1:0]  masked;
    bo_action_t    act;
    bo_result_t    res_q;

    backoff_lfsr #(.WIDTH(LW)) u_lfsr (
        .clk   (clk),
        .rst   (rst),
        .state (lfsr_q)
    );

    backoff_mask #(.W(W), .CW(CW)) u_mask (
        .raw   (lfsr_q[W-1:0]),
        .coll  (coll_cnt),
        .slots (masked)
    );

    backoff_wrap_tracker #(.CW(CW)) u_track (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .partition (partition),
        .coll      (coll_cnt),
        .action    (act)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
        end else begin
            res_q.vld  <= 1'b0;
            res_q.drop <= 1'b0;
            unique case (act)
                ACT_SLOTS: begin
                    res_q.vld   <= 1'b1;
                    res_q.slots <= masked;
                end
                ACT_DISCARD: begin
                    res_q.drop  <= 1'b1;
                    res_q.slots <= '0;
                end
                default: ;
            endcase
        end
    end

    assign slots     = res_q.slots;
    assign slots_vld = res_q.vld;
    assign discard   = res_q.drop;
endmodule

// File: rtl/backoff_gen_chk.sv
module backoff_gen_chk (
    input logic        clk,
    input logic        rst,
    input logic        req,
    input logic [3:0]  coll_cnt,
    input logic        partition,
    input logic [9:0]  slots,
    input logic        slots_vld,
    input logic        discard,
    input logic [15:0] lfsr_state
);
    // R9
    pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(slots_vld && discard));

    // R9
    no_spurious_chk: assert property (@(posedge clk) disable iff (rst)
        !(req && !partition) |=> (!slots_vld && !discard));

    // R8
    partition_block_chk: assert property (@(posedge clk) disable iff (rst)
        (req && partition) |=> (!slots_vld && !discard));

    // R3
    range_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !partition && coll_cnt >= 4'd1 && coll_cnt <= 4'd10)
        |=> (slots_vld && ((slots >> $past(coll_cnt)) == 10'd0)));

    // R4
    capped_vld_chk: assert property (@(posedge clk) disable iff (rst)
        (req && !partition && coll_cnt > 4'd10) |=> slots_vld);

    // R6
    discard_zero_chk: assert property (@(posedge clk) disable iff (rst)
        discard |-> (slots == 10'd0));

    // R2
    lfsr_live_chk: assert property (@(posedge clk) disable iff (rst)
        lfsr_state != 16'd0);

    // R2
    lfsr_shift_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> (lfsr_state[15:1] == $past(lfsr_state[14:0])));
endmodule

bind backoff_gen backoff_gen_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .req        (req),
    .coll_cnt   (coll_cnt),
    .partition  (partition),
    .slots      (slots),
    .slots_vld  (slots_vld),
    .discard    (discard),
    .lfsr_state (lfsr_q)
);

// File: tb/sim_backoff_gen.sv
`timescale 1ns/1ps
module sim_backoff_gen;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       req = 1'b0;
    logic [3:0] coll_cnt = 4'd0;
    logic       partition = 1'b0;
    logic [9:0] slots;
    logic       slots_vld;
    logic       discard;

    int n_chk = 0;
    int n_bad = 0;

    logic [15:0] m_lfsr;
    logic        m_armed;

    always #4 clk = ~clk;

    backoff_gen u0 (
        .clk(clk), .rst(rst), .req(req), .coll_cnt(coll_cnt),
        .partition(partition), .slots(slots), .slots_vld(slots_vld),
        .discard(discard)
    );

    function automatic logic [15:0] ref_next(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    function automatic logic [9:0] ref_slots(input logic [15:0] s, input logic [3:0] n);
        int k;
        k = (n > 4'd10) ? 10 : int'(n);
        return s[9:0] & 10'((1 << k) - 1);
    endfunction

    // bench model of the pseudo-random source
    always @(posedge clk) begin
        if (rst) m_lfsr <= 16'hACE1;
        else     m_lfsr <= ref_next(m_lfsr);
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic [3:0] n, input logic p, input string tag);
        logic       e_vld, e_drop;
        logic [9:0] e_slots;
        req = r; coll_cnt = n; partition = p;
        e_vld = 1'b0; e_drop = 1'b0; e_slots = 10'd0;
        if (r && !p) begin
            if (m_armed && n == 4'd0) begin
                e_drop  = 1'b1;
                m_armed = 1'b0;
            end else begin
                e_vld   = 1'b1;
                e_slots = ref_slots(m_lfsr, n);
                m_armed = (n == 4'd15);
            end
        end
        @(posedge clk);
        @(negedge clk);
        req = 1'b0;
        check({tag, " vld"},  32'(slots_vld), 32'(e_vld));
        check({tag, " drop"}, 32'(discard),   32'(e_drop));
        if (e_vld || e_drop) check({tag, " slots"}, 32'(slots), 32'(e_slots));
    endtask

    initial begin
        #(8 * 200000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        m_armed = 1'b0;
        process::self().srandom(32'd1234);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        check("R1 slots", 32'(slots), 32'd0);
        check("R1 vld",   32'(slots_vld), 32'd0);
        check("R1 drop",  32'(discard), 32'd0);
        rst = 1'b0;

        // R2: after a known number of free-running cycles the LFSR value is predictable
        repeat (37) @(negedge clk);
        step(1'b1, 4'd10, 1'b0, "R2");
        step(1'b1, 4'd1,  1'b0, "R3");
        step(1'b1, 4'd4,  1'b0, "R3");
        step(1'b1, 4'd13, 1'b0, "R4");
        step(1'b1, 4'd0,  1'b0, "R5");
        // R6 wrap to the sixteenth collision
        step(1'b1, 4'd15, 1'b0, "R6");
        step(1'b1, 4'd0,  1'b0, "R6");
        step(1'b1, 4'd0,  1'b0, "R5");
        // R7 repeated 15 keeps armed, other count disarms
        step(1'b1, 4'd15, 1'b0, "R7");
        step(1'b1, 4'd15, 1'b0, "R7");
        step(1'b1, 4'd0,  1'b0, "R7");
        step(1'b1, 4'd15, 1'b0, "R7");
        step(1'b1, 4'd3,  1'b0, "R7");
        step(1'b1, 4'd0,  1'b0, "R7");
        // R8 blocked requests keep armed state
        step(1'b1, 4'd15, 1'b0, "R8");
        step(1'b1, 4'd0,  1'b1, "R8");
        step(1'b1, 4'd5,  1'b1, "R8");
        step(1'b1, 4'd0,  1'b0, "R8");
        // R9 idle cycles produce nothing
        step(1'b0, 4'd7,  1'b0, "R9");
        step(1'b0, 4'd0,  1'b0, "R9");

        for (int i = 0; i < 400; i++) begin
            logic       r, p;
            logic [3:0] n;
            int         sel;
            string      t;
            r   = ($urandom % 3) != 0;
            p   = ($urandom % 5) == 0;
            sel = $urandom % 4;
            n   = (sel == 0) ? 4'd15 : (sel == 1) ? 4'd0 : 4'($urandom);
            if (!r)                      t = "R9";
            else if (p)                  t = "R8";
            else if (m_armed && n == 0)  t = "R6";
            else if (n == 0)             t = "R5";
            else if (n > 4'd10)          t = "R4";
            else                         t = "R3";
            step(r, n, p, t);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule